// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through cache and the next memory level. Each processor store is placed in a small queue. The processor can then continue without waiting for the slower memory. The queued stores are written out to memory one at a time, oldest first, over a single memory port. Reads from the processor share that port.

A read is checked against every store still held in the queue. If the read address matches a queued store, the block answers from the queue with the data of the most recent matching store, and memory is not accessed. If nothing matches, the read is placed on the memory port ahead of any queued store that has not started. A parameter selects a stricter policy instead: the queue is emptied to memory before any read goes out, and no read is answered from the queue. In both policies a read returns the value of the latest store accepted before it.

The processor holds `rd_req` until it sees `rd_ack`. Only one read is in progress at a time. Stores stall on `st_full`.

Top module: `wt_write_buffer`

## Requirements
- R1: While reset is active and on the first cycle after it, `st_full`, `rd_ack` and `mem_req` are low.
- R2: A store is accepted on a clock edge where `st_valid` is high and `st_full` is low. Each accepted store is written to memory exactly once. Writes leave in the order the stores were accepted, with unchanged address and data.
- R3: `st_full` is high when DEPTH (default 4) stores are held, counting a store whose memory write is in progress. A store offered while `st_full` is high is dropped and never reaches memory. `st_full` can fall only after a memory acknowledge.
- R4: `mem_req` stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until the cycle in which `mem_ack` is high, and that cycle completes the transfer. `mem_we` is 1 for a write and 0 for a read. `mem_rdata` is taken in the acknowledge cycle.
- R5: `rd_req` is held until `rd_ack`. `rd_ack` is a one-cycle pulse with the result on `rd_data`. A memory read is issued only while a read request is outstanding.
- R6: In the default mode (DRAIN_BEFORE_READ = 0), a read that matches no queued store goes to memory before every queued store whose write has not started. Only the write already in progress may complete before it.
- R7: In the default mode, a read whose address equals that of one or more queued stores returns the data of the most recently accepted of them. `rd_ack` is high in the cycle after the edge that takes the request, and no memory read is issued for it.
- R8: With DRAIN_BEFORE_READ = 1, a read goes to memory only after every store accepted before it has been written, and it is never answered from the queue.
- R9: In both modes, a read returns the data of the most recent store to that address that was accepted before the read. If there is no such store, it returns the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_full | output | 1 | Queue full, store not taken |
| rd_req | input | 1 | Read request, held until rd_ack |
| rd_addr | input | ADDR_W | Read word address |
| rd_ack | output | 1 | Read result valid (one cycle) |
| rd_data | output | DATA_W | Read result |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transfer completes this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
Two instances, one per read policy, receive the same stimulus. Each has its own memory model that acknowledges at random and can be frozen.

The stimulus patterns and what each one separates:
- **Frozen memory with queued stores.** A read to an unrelated address shows whether the read overtakes the queued writes or waits behind all of them, which is the difference between the two policies.
- **Repeated stores to one address, then a read.** This separates a youngest-match forward from an oldest-match forward and from a wrongful memory access.
- **Filling the queue under frozen memory.** This exposes a store taken while full.
- **Long random mix over sixteen addresses.** Reads and stores are interleaved and compared against a program-order reference. The complete write log is then compared with the accepted-store list to confirm order.

// File: rtl/wb_pkg.sv
package wb_pkg;

   // Read engine states
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_WAIT = 2'd1,
      RD_MEM  = 2'd2,
      RD_DONE = 2'd3
   } rd_state_e;

endpackage

// File: rtl/wb_entry_queue.sv
module wb_entry_queue #(
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 32,
   parameter  int DEPTH  = 4,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [ADDR_W-1:0]             push_addr,
   input  logic [DATA_W-1:0]             push_data,
   input  logic                          pop,
   output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
   output logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
   output logic [DEPTH-1:0]              ent_valid,
   output logic [PTR_W-1:0]              head,
   output logic                          full,
   output logic                          empty,
   output logic [ADDR_W-1:0]             head_addr,
   output logic [DATA_W-1:0]             head_data
);

   logic [PTR_W-1:0] tail;
   logic [CNT_W-1:0] count;

   // Per-slot storage
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && tail == PTR_W'(i)) begin
            ent_addr[i] <= push_addr;
            ent_data[i] <= push_data;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[i] <= 1'b0;
         end else if (push && tail == PTR_W'(i)) begin
            ent_valid[i] <= 1'b1;
         end else if (pop && head == PTR_W'(i)) begin
            ent_valid[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full      = (count == CNT_W'(DEPTH));
   assign empty     = (count == '0);
   assign head_addr = ent_addr[head];
   assign head_data = ent_data[head];

endmodule

// File: rtl/wb_fwd_lookup.sv
module wb_fwd_lookup #(
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 32,
   parameter  int DEPTH  = 4,
   localparam int PTR_W  = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
   input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
   input  logic [DEPTH-1:0]             ent_valid,
   input  logic [PTR_W-1:0]             head,
   input  logic [ADDR_W-1:0]            look_addr,
   output logic                         hit,
   output logic [DATA_W-1:0]            hit_data
);

   // Walk from oldest to youngest; the last match found is the youngest
   always_comb begin
      logic [PTR_W-1:0] slot;
      hit      = 1'b0;
      hit_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         slot = head + PTR_W'(i);
         if (ent_valid[slot] && ent_addr[slot] == look_addr) begin
            hit      = 1'b1;
            hit_data = ent_data[slot];
         end
      end
   end

endmodule

// File: rtl/wb_port_ctrl.sv
module wb_port_ctrl
   import wb_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter bit DRAIN_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ack,
   output logic [DATA_W-1:0] rd_data,
   input  logic              fwd_hit,
   input  logic [DATA_W-1:0] fwd_data,
   input  logic              buf_empty,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [DATA_W-1:0] head_data,
   output logic              pop,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   rd_state_e         st;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] ret_data;
   logic              req_q;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              port_idle;
   logic              xfer_done;
   logic              read_allowed;
   logic              launch_rd;
   logic              launch_wr;

   // Read policy: overtake queued writes, or wait for an empty queue
   if (DRAIN_FIRST) begin : g_drain_gate
      assign read_allowed = buf_empty;
   end else begin : g_bypass_gate
      assign read_allowed = 1'b1;
   end

   assign port_idle = !req_q;
   assign xfer_done = req_q && mem_ack;
   assign launch_rd = port_idle && (st == RD_WAIT) && read_allowed;
   assign launch_wr = port_idle && !buf_empty && !launch_rd;
   assign pop       = xfer_done && we_q;

   // Read engine
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= RD_IDLE;
         pend_addr <= '0;
         ret_data  <= '0;
      end else begin
         case (st)
            RD_IDLE: begin
               if (rd_req) begin
                  if (fwd_hit) begin
                     ret_data <= fwd_data;
                     st       <= RD_DONE;
                  end else begin
                     pend_addr <= rd_addr;
                     st        <= RD_WAIT;
                  end
               end
            end
            RD_WAIT: if (launch_rd) st <= RD_MEM;
            RD_MEM: begin
               if (xfer_done && !we_q) begin
                  ret_data <= mem_rdata;
                  st       <= RD_DONE;
               end
            end
            default: st <= RD_IDLE;
         endcase
      end
   end

   // Memory port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (xfer_done) begin
         req_q <= 1'b0;
      end else if (launch_rd) begin
         req_q  <= 1'b1;
         we_q   <= 1'b0;
         addr_q <= pend_addr;
      end else if (launch_wr) begin
         req_q   <= 1'b1;
         we_q    <= 1'b1;
         addr_q  <= head_addr;
         wdata_q <= head_data;
      end
   end

   assign rd_ack    = (st == RD_DONE);
   assign rd_data   = ret_data;
   assign mem_req   = req_q;
   assign mem_we    = we_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;

endmodule

// File: rtl/wt_write_buffer.sv
module wt_write_buffer #(
   parameter  int ADDR_W            = 32,
   parameter  int DATA_W            = 32,
   parameter  int DEPTH             = 4,
   parameter  bit DRAIN_BEFORE_READ = 1'b0,
   localparam int PTR_W             = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   output logic              st_full,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ack,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert (ADDR_W >= 3 && DATA_W >= 1)
         else $error("address or data width too small");
   end

   logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
   logic [DEPTH-1:0][DATA_W-1:0] ent_data;
   logic [DEPTH-1:0]             ent_valid;
   logic [PTR_W-1:0]             head;
   logic                         buf_full;
   logic                         buf_empty;
   logic [ADDR_W-1:0]            head_addr;
   logic [DATA_W-1:0]            head_data;
   logic                         push;
   logic                         pop;
   logic                         fwd_hit;
   logic [DATA_W-1:0]            fwd_data;

   assign push    = st_valid && !buf_full;
   assign st_full = buf_full;

   wb_entry_queue #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .ent_valid (ent_valid),
      .head      (head),
      .full      (buf_full),
      .empty     (buf_empty),
      .head_addr (head_addr),
      .head_data (head_data)
   );

   // Forwarding exists only in the overtaking variant
   if (DRAIN_BEFORE_READ) begin : g_no_fwd
      assign fwd_hit  = 1'b0;
      assign fwd_data = '0;
   end else begin : g_fwd
      wb_fwd_lookup #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH)
      ) u_lookup (
         .ent_addr  (ent_addr),
         .ent_data  (ent_data),
         .ent_valid (ent_valid),
         .head      (head),
         .look_addr (rd_addr),
         .hit       (fwd_hit),
         .hit_data  (fwd_data)
      );
   end

   wb_port_ctrl #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .DRAIN_FIRST (DRAIN_BEFORE_READ)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_ack    (rd_ack),
      .rd_data   (rd_data),
      .fwd_hit   (fwd_hit),
      .fwd_data  (fwd_data),
      .buf_empty (buf_empty),
      .head_addr (head_addr),
      .head_data (head_data),
      .pop       (pop),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

endmodule

// File: rtl/wb_checker.sv
module wb_checker #(
   parameter int ADDR_W            = 32,
   parameter int DATA_W            = 32,
   parameter bit DRAIN_BEFORE_READ = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_full,
   input logic              rd_req,
   input logic              rd_ack,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              buf_empty
);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!st_full && !rd_ack && !mem_req));

   assert_full_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_full && !mem_ack) |=> st_full);

   assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));

   assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |=> !rd_ack);

   assert_read_has_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> rd_req);

   // R7: no memory read is pending while a result is returned
   assert_no_read_at_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |-> !(mem_req && !mem_we));

   if (DRAIN_BEFORE_READ) begin : g_drain_chk
      assert_read_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_req && !mem_we) |-> buf_empty);
   end

endmodule

bind wt_write_buffer wb_checker #(
   .ADDR_W            (ADDR_W),
   .DATA_W            (DATA_W),
   .DRAIN_BEFORE_READ (DRAIN_BEFORE_READ)
) u_wb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_full   (st_full),
   .rd_req    (rd_req),
   .rd_ack    (rd_ack),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .buf_empty (buf_empty)
);

// File: tb/test_wt_write_buffer.sv
module wb_mem_model (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hold,
   input  logic        req,
   input  logic        we,
   input  logic [31:0] addr,
   input  logic [31:0] wdata,
   output logic        ack,
   output logic [31:0] rdata
);
   logic [31:0] mem     [64];
   logic [31:0] wlog_a  [1024];
   logic [31:0] wlog_d  [1024];
   int          rd_snap [1024];
   int          n_wr;
   int          n_rd;

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | 32'(i);
      n_wr  = 0;
      n_rd  = 0;
      ack   = 1'b0;
      rdata = '0;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         ack = 1'b0;
      end else if (ack) begin
         ack = 1'b0;
      end else if (req && !hold && ($urandom % 2 == 0)) begin
         ack = 1'b1;
         if (we) begin
            mem[addr[7:2]] = wdata;
            wlog_a[n_wr]   = addr;
            wlog_d[n_wr]   = wdata;
            n_wr++;
         end else begin
            rdata         = mem[addr[7:2]];
            rd_snap[n_rd] = n_wr;
            n_rd++;
         end
      end
   end
endmodule

module test_wt_write_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold = 1'b0;
   logic        st_valid = 1'b0;
   logic [31:0] st_addr = '0;
   logic [31:0] st_data = '0;
   logic        rd_req_a = 1'b0;
   logic        rd_req_b = 1'b0;
   logic [31:0] rd_addr = '0;

   logic        full_a, full_b, ack_a, ack_b;
   logic [31:0] rdat_a, rdat_b;
   logic        mreq_a, mwe_a, mack_a, mreq_b, mwe_b, mack_b;
   logic [31:0] maddr_a, mwd_a, mrd_a, maddr_b, mwd_b, mrd_b;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] ref_mem [64];
   logic [31:0] exp_a   [1024];
   logic [31:0] exp_d   [1024];
   int          n_exp = 0;
   int          seed_init;

   always #2 clk = ~clk;

   wt_write_buffer #(.DRAIN_BEFORE_READ(1'b0)) i_wt_write_buffer (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
      .st_data(st_data), .st_full(full_a), .rd_req(rd_req_a), .rd_addr(rd_addr),
      .rd_ack(ack_a), .rd_data(rdat_a), .mem_req(mreq_a), .mem_we(mwe_a),
      .mem_addr(maddr_a), .mem_wdata(mwd_a), .mem_ack(mack_a), .mem_rdata(mrd_a));

   wt_write_buffer #(.DRAIN_BEFORE_READ(1'b1)) i_wt_write_buffer_drain (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
      .st_data(st_data), .st_full(full_b), .rd_req(rd_req_b), .rd_addr(rd_addr),
      .rd_ack(ack_b), .rd_data(rdat_b), .mem_req(mreq_b), .mem_we(mwe_b),
      .mem_addr(maddr_b), .mem_wdata(mwd_b), .mem_ack(mack_b), .mem_rdata(mrd_b));

   wb_mem_model m_byp (.clk(clk), .rst_n(rst_n), .hold(hold), .req(mreq_a), .we(mwe_a),
      .addr(maddr_a), .wdata(mwd_a), .ack(mack_a), .rdata(mrd_a));
   wb_mem_model m_drn (.clk(clk), .rst_n(rst_n), .hold(hold), .req(mreq_b), .we(mwe_b),
      .addr(maddr_b), .wdata(mwd_b), .ack(mack_b), .rdata(mrd_b));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Offer a store once both instances have room; both accept it
   task automatic do_store(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      while (full_a || full_b) @(negedge clk);
      st_valid = 1'b1;
      st_addr  = a;
      st_data  = d;
      ref_mem[a[7:2]] = d;
      exp_a[n_exp] = a;
      exp_d[n_exp] = d;
      n_exp++;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic do_read(input logic [31:0] a, input int rel,
                          output logic [31:0] da, output logic [31:0] db,
                          output int ca);
      bit done_a = 1'b0;
      bit done_b = 1'b0;
      ca = -1;
      da = '0;
      db = '0;
      @(negedge clk);
      rd_addr  = a;
      rd_req_a = 1'b1;
      rd_req_b = 1'b1;
      for (int k = 1; k < 400 && !(done_a && done_b); k++) begin
         @(negedge clk);
         if (k == rel) hold = 1'b0;
         if (ack_a && !done_a) begin
            done_a = 1'b1; da = rdat_a; ca = k; rd_req_a = 1'b0;
         end
         if (ack_b && !done_b) begin
            done_b = 1'b1; db = rdat_b; rd_req_b = 1'b0;
         end
      end
      rd_req_a = 1'b0;
      rd_req_b = 1'b0;
   endtask

   task automatic wait_drain();
      for (int k = 0; k < 500; k++) begin
         @(negedge clk);
         if (m_byp.n_wr == n_exp && m_drn.n_wr == n_exp) break;
      end
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "R5", "watchdog expired", 32'd0, 32'd1);
      summary();
   end

   initial begin
      logic [31:0] da, db, ev;
      int          ca, nra, nrb, base;
      seed_init = $urandom(32'd20240611);
      for (int i = 0; i < 64; i++) ref_mem[i] = 32'hA500_0000 | 32'(i);

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      chk(!full_a && !full_b, "R1", "st_full after reset", {30'd0, full_a, full_b}, 0);
      chk(!ack_a && !ack_b, "R1", "rd_ack after reset", {30'd0, ack_a, ack_b}, 0);
      chk(!mreq_a && !mreq_b, "R1", "mem_req after reset", {30'd0, mreq_a, mreq_b}, 0);

      // R3: fill under frozen memory, offer an extra store
      hold = 1'b1;
      for (int i = 0; i < 4; i++) do_store(32'h10 + 32'(i * 4), 32'h1111_0000 + 32'(i));
      @(negedge clk);
      chk(full_a && full_b, "R3", "st_full with four held", {30'd0, full_a, full_b}, 3);
      st_valid = 1'b1; st_addr = 32'h40; st_data = 32'hDEAD_0040;
      @(negedge clk);
      st_valid = 1'b0;
      chk(full_a && full_b, "R3", "still full, memory frozen", {30'd0, full_a, full_b}, 3);
      hold = 1'b0;
      wait_drain();
      chk(!full_a && !full_b, "R3", "full clears after drain", {30'd0, full_a, full_b}, 0);
      do_read(32'h40, -1, da, db, ca);
      chk(da == ref_mem[16], "R3", "dropped store reached memory (bypass)", da, ref_mem[16]);
      chk(db == ref_mem[16], "R3", "dropped store reached memory (drain)", db, ref_mem[16]);

      // R6 / R8: read to an unrelated address behind three queued writes
      wait_drain();
      hold = 1'b1;
      do_store(32'h20, 32'h2222_0020);
      do_store(32'h24, 32'h2222_0024);
      do_store(32'h28, 32'h2222_0028);
      base = m_byp.n_wr;
      nra = m_byp.n_rd;
      nrb = m_drn.n_rd;
      do_read(32'h80, 3, da, db, ca);
      chk(m_byp.rd_snap[nra] == base + 1, "R6", "writes done before overtaking read",
          32'(m_byp.rd_snap[nra]), 32'(base + 1));
      chk(m_drn.rd_snap[nrb] == base + 3, "R8", "writes done before read (drain)",
          32'(m_drn.rd_snap[nrb]), 32'(base + 3));
      chk(da == ref_mem[32], "R9", "overtaking read data", da, ref_mem[32]);
      chk(db == ref_mem[32], "R9", "drain read data", db, ref_mem[32]);

      // R7: two stores to one address, forwarded while memory is frozen
      wait_drain();
      hold = 1'b1;
      do_store(32'h30, 32'h3333_0001);
      do_store(32'h30, 32'h3333_0002);
      do_store(32'h34, 32'h3333_0034);
      nra = m_byp.n_rd;
      nrb = m_drn.n_rd;
      do_read(32'h30, 4, da, db, ca);
      chk(da == 32'h3333_0002, "R7", "youngest match forwarded", da, 32'h3333_0002);
      chk(ca == 1, "R7", "forward latency in cycles", 32'(ca), 32'd1);
      chk(m_byp.n_rd == nra, "R7", "memory reads during forward", 32'(m_byp.n_rd), 32'(nra));
      chk(db == 32'h3333_0002, "R9", "drain instance read data", db, 32'h3333_0002);
      chk(m_drn.n_rd == nrb + 1, "R8", "drain instance reads memory", 32'(m_drn.n_rd), 32'(nrb + 1));

      // Random mix over sixteen words
      hold = 1'b0;
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a;
         a = 32'(($urandom % 16) * 4);
         if ($urandom % 10 < 6) begin
            do_store(a, $urandom);
         end else begin
            ev = ref_mem[a[7:2]];
            do_read(a, -1, da, db, ca);
            chk(da == ev, "R9", "random read (bypass)", da, ev);
            chk(db == ev, "R9", "random read (drain)", db, ev);
         end
      end

      // R2: write logs match accepted stores in order
      wait_drain();
      chk(m_byp.n_wr == n_exp, "R2", "write count (bypass)", 32'(m_byp.n_wr), 32'(n_exp));
      chk(m_drn.n_wr == n_exp, "R2", "write count (drain)", 32'(m_drn.n_wr), 32'(n_exp));
      begin
         int bad_a = -1;
         int bad_b = -1;
         for (int i = 0; i < n_exp; i++) begin
            if (bad_a < 0 && (m_byp.wlog_a[i] != exp_a[i] || m_byp.wlog_d[i] != exp_d[i])) bad_a = i;
            if (bad_b < 0 && (m_drn.wlog_a[i] != exp_a[i] || m_drn.wlog_d[i] != exp_d[i])) bad_b = i;
         end
         chk(bad_a < 0, "R2", "write order (bypass) first bad index", 32'(bad_a), 32'hFFFF_FFFF);
         chk(bad_b < 0, "R2", "write order (drain) first bad index", 32'(bad_b), 32'hFFFF_FFFF);
      end
      for (int i = 0; i < 16; i++) begin
         ev = ref_mem[i];
         do_read(32'(i * 4), -1, da, db, ca);
         chk(da == ev && db == ev, "R9", "final memory image", da, ev);
      end
      summary();
   end
endmodule